// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A first-in first-out buffer for 9-bit words whose write side and read side run on unrelated clocks. Each side keeps its own binary pointer and hands the other side a Gray-coded copy through a two-flop synchronizer. The full and almost-full flags are computed in the write domain. The empty and almost-empty flags are computed in the read domain. All four flags are active low.

One control input, `wen2_ld`, has two roles. Its level while reset is held picks the role, and the role stays fixed until the next reset.

- If `wen2_ld` is high during reset, the input acts as a second, active-high write enable.
- If `wen2_ld` is low during reset, the input acts as a load strobe. While the strobe is low, write-side accesses program the two flag thresholds over the data input bus, and read-side accesses return the thresholds on the data output bus. The thresholds are visited almost-empty first, then almost-full, and the order repeats. Writes and reads each keep their own position in this order.

The output enable is modelled by two signals: `rd_drive`, and a data bus that is forced to zero while it is released.

Each side has two small state machines: a role register (`PIN_WEN2` / `PIN_LOAD`) and a threshold selector (`SEL_AE` / `SEL_AF`).

- Role register: it is loaded from `wen2_ld` on every clock edge while reset is held. It holds its value otherwise (transition "latch at reset", no other transition).
- Threshold selector: reset puts it in `SEL_AE`. A threshold access takes it `SEL_AE -> SEL_AF` ("first access") or `SEL_AF -> SEL_AE` ("second access"). Any other cycle leaves it in place.

Top module: `dcfifo_pf`

## Requirements
- R1: While `rst_n` is low and for one clock edge on each side, the block returns to its idle values. These are `empty_n`=0, `full_n`=1, `almost_empty_n`=0, `almost_full_n`=1, data register 0, both thresholds 7, and both selectors at `SEL_AE`.
- R2: `wen2_ld` high during reset selects second-write-enable role; low selects load role; the role is held until the next reset.
- R3: A word is stored on a rising `wr_clk` only when `wr_en1_n`=0, `wen2_ld`=1 and `full_n`=1. Any other combination stores nothing and moves no pointer.
- R4: A word is popped on a rising `rd_clk` only under all of the following conditions: `rd_en1_n`=0, `rd_en2_n`=0, `empty_n`=1, and (in load role) `wen2_ld`=1. Words come out in write order across pointer wrap. A read attempted while empty leaves the data register unchanged.
- R5: Once the pointers have crossed (at most four cycles of the observing clock), `empty_n` is 0 exactly when the FIFO holds 0 words, and `full_n` is 0 exactly when it holds DEPTH words (16 by default).
- R6: `almost_empty_n` is 0 when the stored word count is at or below the almost-empty threshold.
- R7: `almost_full_n` is 0 when DEPTH minus the stored word count is at or below the almost-full threshold.
- R8: In load role, a rising `wr_clk` with `wr_en1_n`=0 and `wen2_ld`=0 copies `wr_data[AW-1:0]` into the selected threshold: almost-empty first, then almost-full, alternating. The FIFO contents are untouched.
- R9: In load role, a rising `rd_clk` with both read enables low and `wen2_ld`=0 loads the selected threshold, zero-extended, into the data register: almost-empty first, then almost-full, alternating. No word is popped.
- R10: With `oe_n`=1, `rd_data` is 0 and `rd_drive` is 0. With `oe_n`=0, `rd_data` shows the data register and `rd_drive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous reset, active low, seen by both clocks |
| wr_data | input | 9 | Word to store, or threshold value in load role |
| wr_en1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write enable or threshold-load strobe, role fixed at reset |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 9 | Data register, zero while released |
| rd_drive | output | 1 | High when the output bus is driven |
| empty_n | output | 1 | Empty flag, read domain, active low |
| full_n | output | 1 | Full flag, write domain, active low |
| almost_empty_n | output | 1 | Programmable almost-empty flag, read domain |
| almost_full_n | output | 1 | Programmable almost-full flag, write domain |

## Verification
The embedded properties check, on every cycle, the following:

- No pointer moves while its side sees full or empty.
- A threshold write never moves the write pointer.
- The role register never changes outside reset.
- Each threshold readback flips the read selector.
- The full and empty flags always imply their "almost" partners.

Only the bench scenarios can show the remaining behaviour:

- Data order across pointer wrap.
- The exact flag values at every fill level from 0 to 16 under both default and reprogrammed thresholds.
- The alternating threshold order.
- That ignored enables and wrong-role strobes leave the observable outputs unchanged.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        PIN_WEN2 = 1'b0,
        PIN_LOAD = 1'b1
    } pin_mode_e;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW      = 4,
    parameter int OFS_DEF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en1_n,
    input  logic          wen2_ld,
    input  logic [AW-1:0] ofs_din,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic          full_n,
    output logic          almost_full_n,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    pin_mode_e     mode;
    ofs_sel_e      wsel;
    logic [PW-1:0] wbin, wbin_nx, rbin_s, level, free;
    logic          push, ofs_wr;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // outputs and next-state decode
    always_comb begin
        rbin_s        = g2b(rgray_s);
        level         = wbin - rbin_s;
        free          = PW'(DEPTH) - level;
        full_n        = (level != PW'(DEPTH));
        almost_full_n = !(free <= {1'b0, af_ofs});
        push          = !wr_en1_n && wen2_ld && full_n;
        ofs_wr        = (mode == PIN_LOAD) && !wr_en1_n && !wen2_ld;
        wbin_nx       = wbin + PW'(1);
        mem_we        = push;
        waddr         = wbin[AW-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= wen2_ld ? PIN_WEN2 : PIN_LOAD;
            wsel   <= SEL_AE;
            ae_ofs <= AW'(OFS_DEF);
            af_ofs <= AW'(OFS_DEF);
            wbin   <= '0;
            wgray  <= '0;
        end else begin
            if (push) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (ofs_wr) begin
                unique case (wsel)
                    SEL_AE: begin
                        ae_ofs <= ofs_din;
                        wsel   <= SEL_AF;
                    end
                    SEL_AF: begin
                        af_ofs <= ofs_din;
                        wsel   <= SEL_AE;
                    end
                endcase
            end
        end
    end

    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> $stable(wbin));
    a_r8_load_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_wr |=> $stable(wbin));
    a_r2_role_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode));
    a_r7_full_implies_afull: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic          wen2_ld,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q,
    output logic          empty_n,
    output logic          almost_empty_n
);
    localparam int PW = AW + 1;

    pin_mode_e     mode;
    ofs_sel_e      rsel;
    logic [PW-1:0] rbin, rbin_nx, wbin_s, level;
    logic [AW-1:0] sel_ofs;
    logic          both_en, strobe, pop, ofs_rd;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // outputs and next-state decode
    always_comb begin
        wbin_s         = g2b(wgray_s);
        level          = wbin_s - rbin;
        empty_n        = (level != '0);
        almost_empty_n = !(level <= {1'b0, ae_ofs});
        both_en        = !rd_en1_n && !rd_en2_n;
        strobe         = (mode == PIN_LOAD) && !wen2_ld;
        pop            = both_en && empty_n && !strobe;
        ofs_rd         = both_en && strobe;
        rbin_nx        = rbin + PW'(1);
        raddr          = rbin[AW-1:0];
        sel_ofs        = (rsel == SEL_AE) ? ae_ofs : af_ofs;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= wen2_ld ? PIN_WEN2 : PIN_LOAD;
            rsel  <= SEL_AE;
            rbin  <= '0;
            rgray <= '0;
            q     <= '0;
        end else begin
            if (pop) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
                q     <= mem_rdata;
            end else if (ofs_rd) begin
                q <= DW'(sel_ofs);
                unique case (rsel)
                    SEL_AE: rsel <= SEL_AF;
                    SEL_AF: rsel <= SEL_AE;
                endcase
            end
        end
    end

    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> $stable(rbin));
    a_r9_readback_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_rd |=> (rsel != $past(rsel)));
    a_r6_empty_implies_aempty: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);
    a_r2_role_held_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode));
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf #(
    parameter int DW      = 9,
    parameter int AW      = 4,
    parameter int OFS_DEF = 7
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en1_n,
    input  logic          wen2_ld,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic          oe_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive,
    output logic          empty_n,
    output logic          full_n,
    output logic          almost_empty_n,
    output logic          almost_full_n
);
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, ae_ofs, af_ofs;
    logic [DW-1:0] mem_rdata, q;
    logic          mem_we;

    dcf_wr_side #(.AW(AW), .OFS_DEF(OFS_DEF)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wen2_ld(wen2_ld),
        .ofs_din(wr_data[AW-1:0]), .rgray_s(rgray_s), .wgray(wgray),
        .waddr(waddr), .mem_we(mem_we), .full_n(full_n),
        .almost_full_n(almost_full_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .wen2_ld(wen2_ld), .wgray_s(wgray_s), .mem_rdata(mem_rdata),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .raddr(raddr), .rgray(rgray),
        .q(q), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dcf_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    assign rd_data  = oe_n ? '0 : q;
    assign rd_drive = !oe_n;
endmodule

// File: tb/tb_dcfifo_pf.sv
module tb_dcfifo_pf;
    localparam int DEPTH = 16;

    logic       wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic [8:0] wr_data = '0;
    logic       wr_en1_n = 1, wen2_ld = 1, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
    logic [8:0] rd_data;
    logic       rd_drive, empty_n, full_n, almost_empty_n, almost_full_n;

    int checks = 0, errors = 0;
    bit done = 0;
    int exp_q [64];
    int head = 0, tail = 0, seq = 0;
    int last_word = 0;

    dcfifo_pf dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en1_n(wr_en1_n), .wen2_ld(wen2_ld), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .oe_n(oe_n), .rd_data(rd_data), .rd_drive(rd_drive),
        .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        #2;
    endtask

    task automatic do_reset(bit role_wen2);
        @(negedge wr_clk);
        rst_n = 0; wen2_ld = role_wen2; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
        repeat (5) @(posedge wr_clk);
        repeat (5) @(posedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1;
        head = 0; tail = 0;
        settle();
    endtask

    task automatic wr_cycle(int data, bit en1_n, bit w2);
        @(negedge wr_clk);
        wr_data = 9'(data); wr_en1_n = en1_n; wen2_ld = w2;
        @(negedge wr_clk);
        wr_en1_n = 1; wen2_ld = 1;
    endtask

    task automatic rd_cycle(bit e1, bit e2, bit w2);
        @(negedge rd_clk);
        rd_en1_n = e1; rd_en2_n = e2; wen2_ld = w2;
        @(negedge rd_clk);
        rd_en1_n = 1; rd_en2_n = 1; wen2_ld = 1;
    endtask

    task automatic check_flags(int k, int ae, int af, string tag);
        chk("R5", {tag, " empty_n"}, empty_n, int'(k > 0));
        chk("R5", {tag, " full_n"}, full_n, int'(k < DEPTH));
        chk("R6", {tag, " almost_empty_n"}, almost_empty_n, int'(!(k <= ae)));
        chk("R7", {tag, " almost_full_n"}, almost_full_n, int'(!(DEPTH - k <= af)));
    endtask

    task automatic push_word();
        int w;
        w = (seq * 37 + 5) & 9'h1FF;
        seq++;
        exp_q[tail % 64] = w;
        tail++;
        wr_cycle(w, 0, 1);
    endtask

    task automatic fill_drain(int ae, int af, bit w2_on_read, string tag);
        for (int k = 1; k <= DEPTH; k++) begin
            push_word();
            settle();
            check_flags(k, ae, af, {tag, " fill"});
        end
        // R3: writes while full are ignored
        wr_cycle(9'h1AA, 0, 1);
        settle();
        check_flags(DEPTH, ae, af, {tag, " R3 write-when-full"});
        for (int k = DEPTH - 1; k >= 0; k--) begin
            rd_cycle(0, 0, w2_on_read);
            settle();
            chk("R4", {tag, " order"}, rd_data, exp_q[head % 64]);
            last_word = exp_q[head % 64];
            head++;
            check_flags(k, ae, af, {tag, " drain"});
        end
    endtask

    initial begin
        // Phase A: second-write-enable role
        do_reset(1);
        chk("R1", "empty_n", empty_n, 0);
        chk("R1", "full_n", full_n, 1);
        chk("R1", "almost_empty_n", almost_empty_n, 0);
        chk("R1", "almost_full_n", almost_full_n, 1);
        chk("R1", "rd_data", rd_data, 0);
        chk("R10", "rd_drive", rd_drive, 1);

        // R3: partial enables ignored
        wr_cycle(9'h055, 0, 0);
        wr_cycle(9'h066, 1, 1);
        settle();
        chk("R3", "empty after wen2 low", empty_n, 0);

        // R2/R4: in this role reads ignore wen2_ld level
        for (int pass = 0; pass < 2; pass++) begin
            fill_drain(7, 7, 1'(pass), "A");
        end

        // R4: read while empty keeps data register
        rd_cycle(0, 0, 1);
        settle();
        chk("R4", "hold on empty read", rd_data, last_word);
        chk("R5", "still empty", empty_n, 0);

        // R4: single read enable ignored
        push_word();
        settle();
        rd_cycle(0, 1, 1);
        rd_cycle(1, 0, 1);
        settle();
        chk("R4", "single enable no pop", rd_data, last_word);
        chk("R4", "single enable keeps word", empty_n, 1);

        // R10: output released
        oe_n = 1;
        #1;
        chk("R10", "released data", rd_data, 0);
        chk("R10", "released drive", rd_drive, 0);
        oe_n = 0;
        #1;
        rd_cycle(0, 0, 1);
        settle();
        chk("R4", "late pop", rd_data, exp_q[head % 64]);
        head++;

        // Phase B: load role
        do_reset(0);
        chk("R1", "empty after reset B", empty_n, 0);
        rd_cycle(0, 0, 0);
        settle();
        chk("R9", "default ae readback", rd_data, 7);
        rd_cycle(0, 0, 0);
        settle();
        chk("R9", "default af readback", rd_data, 7);
        chk("R9", "no pop on readback", empty_n, 0);

        wr_cycle(3, 0, 0);
        wr_cycle(12, 0, 0);
        settle();
        chk("R8", "threshold write stores nothing", empty_n, 0);
        rd_cycle(0, 0, 0);
        settle();
        chk("R8", "ae programmed", rd_data, 3);
        rd_cycle(0, 0, 0);
        settle();
        chk("R8", "af programmed", rd_data, 12);
        rd_cycle(0, 0, 0);
        settle();
        chk("R9", "order wraps to ae", rd_data, 3);
        rd_cycle(0, 0, 0);
        settle();
        chk("R9", "selector back to af", rd_data, 12);

        fill_drain(3, 12, 1, "B");

        // R9: readback while holding words does not pop
        push_word();
        settle();
        rd_cycle(0, 0, 0);
        settle();
        chk("R9", "readback with data", rd_data, 3);
        chk("R9", "word kept", empty_n, 1);
        rd_cycle(0, 0, 1);
        settle();
        chk("R4", "pop after readback", rd_data, exp_q[head % 64]);
        head++;

        // R2: role held; wen2_ld low is a threshold access again
        wr_cycle(9'h005, 0, 0);
        settle();
        chk("R2", "load role held", empty_n, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule